// File: doc/BRIEF.md
# Byte-Synchronous Receiver with Programmable Sync Pattern

The block is the receive side of a byte-synchronous serial link. A line front end hands it one sampled data bit at a time, qualified by a bit strobe. While hunting, the block slides a window over the incoming bits and looks for a sync pattern whose length software picks: one, two, three or four bytes. The first bit after a match starts byte alignment. From then on the block packs bits into bytes, most significant bit first, and presents each byte for one clock. It can also count the bytes of a fixed-length packet, mark the last byte as end of frame, and fall back to hunting without help.

Software sets the block up through two 32-bit registers that share one write-data bus: a pattern register and a control register. A 3-bit mode input enables the receiver only for one code. A force-hunt input lets the host drop synchronization at any time.

The controller is a three-state machine. `ST_IDLE` is the state while the mode code is anything other than the enabling value. `ST_HUNT` searches for the pattern. `ST_SYNC` assembles bytes. The transitions are as follows. Leaving the enabling mode sends any state to `ST_IDLE`. A register write or force-hunt sends any state to `ST_HUNT`. `ST_IDLE` moves to `ST_HUNT` on the first clock with the enabling mode. `ST_HUNT` moves to `ST_SYNC` on a pattern match. `ST_SYNC` moves to `ST_HUNT` on the byte that reaches the terminal count.

Top module: `bsr_top`

## Requirements
- R1: After synchronous reset `rst`, `byte_vld`, `byte_eof`, `sync_det` and `in_sync` are all 0, and both registers read as zero (1-byte pattern 0x00, terminal count disabled).
- R2: The receiver works only while `mode_sel` equals 3'b101. On any clock edge where `mode_sel` has another value, the block goes to idle: `in_sync` is 0 afterwards, and bits arriving in idle produce neither sync nor bytes.
- R3: Control bits [18:17] set the pattern length N as the value plus one. The pattern is held in pattern bits [8N-1:0], and bit 8N-1 is the oldest bit on the line. A match means the last 8N strobed bits equal that field.
- R4: A match is only accepted once at least 8N bits have been strobed since hunting last began. Bits seen before entering hunt never take part in a match.
- R5: The clock edge that takes in the last bit of a match makes `sync_det` 1 for exactly one clock and makes `in_sync` 1.
- R6: In sync, bits are packed MSB first. The edge that takes in the 8th bit of a byte makes `byte_vld` 1 for one clock with the byte on `byte_out`. Sync-pattern bits are never output. Gaps between bit strobes do not disturb assembly.
- R7: When control bit 16 is 1, control bits [15:0] hold the packet length minus one. The byte whose index in the packet equals that value comes out with `byte_eof` 1, and on the same edge `in_sync` drops and hunting restarts.
- R8: When control bit 16 is 0, `byte_eof` stays 0 and the block stays in sync for any number of bytes.
- R9: A clock with `force_hunt` 1 puts the block into hunt, with `in_sync` 0 afterwards. It drops any partly assembled byte and any byte that would have completed on that edge.
- R10: A write to either register (`pat_we` or `ctl_we`) puts the block into hunt and clears the bit and byte counters, exactly as R9 does. If both strobes are 1 on the same clock, both registers are written.
- R11: Control bits [31:19] have no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wdata | input | 32 | Write data for both configuration registers |
| pat_we | input | 1 | Write strobe for the pattern register |
| ctl_we | input | 1 | Write strobe for the control register |
| mode_sel | input | 3 | Receiver mode code; 3'b101 enables this receiver |
| force_hunt | input | 1 | Forces a return to hunt |
| bit_vld | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Sampled serial data bit |
| byte_vld | output | 1 | One-clock strobe for a completed byte |
| byte_out | output | 8 | Assembled byte |
| byte_eof | output | 1 | The byte on `byte_out` ends a fixed-length packet |
| in_sync | output | 1 | Receiver is byte-aligned and assembling |
| sync_det | output | 1 | One-clock pulse on a pattern match |

## Verification
The assertions take it as given that the bit strobe comes at most once per clock and that the inputs are held stable for a whole clock period. They also assume that configuration writes, force-hunt and mode changes are single-cycle events, which none of the assertions need to be ordered against. The stimulus respects these conditions by construction. Every input changes only between clock edges, a bit strobe never lasts longer than one clock, and strobe gaps are random idle clocks inserted between bits. Mode changes and force-hunt are applied in clocks that carry no bit, so the expected drop of partial bytes can be worked out directly.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam logic [2:0] MODE_XSYNC = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_SYNC = 2'd2
    } bsr_state_e;

endpackage

// File: rtl/bsr_cfg.sv
module bsr_cfg #(
    parameter int REG_W     = 32,
    parameter int BYTE_W    = 8,
    parameter int MAX_SYNC  = 4,
    parameter int CNT_W     = 16,
    localparam int WIN_W    = BYTE_W * MAX_SYNC,
    localparam int LEN_W    = (MAX_SYNC > 1) ? $clog2(MAX_SYNC) : 1,
    localparam int EN_BIT   = CNT_W,
    localparam int LEN_LSB  = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_W-1:0]   wdata,
    input  logic               pat_we,
    input  logic               ctl_we,
    output logic [WIN_W-1:0]   pattern,
    output logic [LEN_W-1:0]   len_sel,
    output logic               tc_en,
    output logic [CNT_W-1:0]   tc_val
);

    // pattern register: only the low WIN_W bits are stored
    always_ff @(posedge clk) begin
        if (rst) begin
            pattern <= '0;
        end else if (pat_we) begin
            pattern <= wdata[WIN_W-1:0];
        end
    end

    // control register: only the decoded fields are stored, the rest are dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            len_sel <= '0;
            tc_en   <= 1'b0;
            tc_val  <= '0;
        end else if (ctl_we) begin
            len_sel <= wdata[LEN_LSB +: LEN_W];
            tc_en   <= wdata[EN_BIT];
            tc_val  <= wdata[CNT_W-1:0];
        end
    end

    // R11: the stored count follows the low write-data bits only
    a_r11_tc_field: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (tc_val == $past(wdata[CNT_W-1:0])));

    // R3: the length field is taken from its own bit position
    a_r3_len_field: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (len_sel == $past(wdata[LEN_LSB +: LEN_W])));

endmodule

// File: rtl/bsr_hunt.sv
module bsr_hunt #(
    parameter int BYTE_W    = 8,
    parameter int MAX_SYNC  = 4,
    localparam int WIN_W    = BYTE_W * MAX_SYNC,
    localparam int LEN_W    = (MAX_SYNC > 1) ? $clog2(MAX_SYNC) : 1,
    localparam int FILL_W   = $clog2(WIN_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               shift,
    input  logic               bit_in,
    input  logic [WIN_W-1:0]   pattern,
    input  logic [LEN_W-1:0]   len_sel,
    output logic               match
);

    logic [WIN_W-1:0]   win_q;
    logic [WIN_W-1:0]   win_next;
    logic [FILL_W-1:0]  fill_q;
    logic [FILL_W:0]    need_bits;
    logic               filled;
    logic [MAX_SYNC-1:0] byte_ok;

    assign win_next  = {win_q[WIN_W-2:0], bit_in};
    assign need_bits = (FILL_W + 1)'((int'(len_sel) + 1) * BYTE_W);
    assign filled    = ({1'b0, fill_q} + 1'b1) >= need_bits;

    // per-byte comparison; bytes above the selected length always agree
    for (genvar gi = 0; gi < MAX_SYNC; gi++) begin : g_cmp
        localparam logic [LEN_W-1:0] IDX = LEN_W'(gi);
        assign byte_ok[gi] = (IDX > len_sel) ||
            (win_next[gi*BYTE_W +: BYTE_W] == pattern[gi*BYTE_W +: BYTE_W]);
    end

    assign match = shift && filled && (&byte_ok);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (shift) begin
            win_q <= win_next;
            if (fill_q != FILL_W'(WIN_W)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // R4: a clear empties the fill counter, so no match can follow directly
    a_r4_fill_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fill_q == '0));

endmodule

// File: rtl/bsr_assemble.sv
module bsr_assemble #(
    parameter int BYTE_W   = 8,
    parameter int CNT_W    = 16,
    localparam int BCW     = $clog2(BYTE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               shift,
    input  logic               bit_in,
    input  logic               tc_en,
    input  logic [CNT_W-1:0]   tc_val,
    output logic               byte_done,
    output logic [BYTE_W-1:0]  byte_data,
    output logic               byte_last
);

    localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W - 1);

    logic [BYTE_W-2:0]  sh_q;
    logic [BCW-1:0]     bitcnt_q;
    logic [CNT_W-1:0]   bytecnt_q;

    assign byte_done = shift && (bitcnt_q == BIT_LAST);
    assign byte_data = {sh_q, bit_in};
    assign byte_last = tc_en && (bytecnt_q == tc_val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q      <= '0;
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
        end else if (shift) begin
            sh_q <= {sh_q[BYTE_W-3:0], bit_in};
            if (byte_done) begin
                bitcnt_q  <= '0;
                bytecnt_q <= bytecnt_q + 1'b1;
            end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    // R10: after a clear, assembly restarts at bit zero of byte zero
    a_r10_counters_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bitcnt_q == '0 && bytecnt_q == '0));

endmodule

// File: rtl/bsr_top.sv
module bsr_top
    import bsr_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int BYTE_W   = 8,
    parameter int MAX_SYNC = 4,
    parameter int CNT_W    = 16,
    localparam int WIN_W   = BYTE_W * MAX_SYNC,
    localparam int LEN_W   = (MAX_SYNC > 1) ? $clog2(MAX_SYNC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               pat_we,
    input  logic               ctl_we,
    input  logic [2:0]         mode_sel,
    input  logic               force_hunt,
    input  logic               bit_vld,
    input  logic               bit_in,
    output logic               byte_vld,
    output logic [BYTE_W-1:0]  byte_out,
    output logic               byte_eof,
    output logic               in_sync,
    output logic               sync_det
);

    bsr_state_e         state_q;
    bsr_state_e         state_d;

    logic [WIN_W-1:0]   pattern;
    logic [LEN_W-1:0]   len_sel;
    logic               tc_en;
    logic [CNT_W-1:0]   tc_val;

    logic               mode_ok;
    logic               cfg_wr;
    logic               restart;
    logic               hunt_shift;
    logic               asm_shift;
    logic               hunt_clr;
    logic               asm_clr;
    logic               hit;
    logic               byte_done;
    logic [BYTE_W-1:0]  byte_data;
    logic               byte_last;
    logic               close_pkt;

    assign mode_ok    = (mode_sel == MODE_XSYNC);
    assign cfg_wr     = pat_we || ctl_we;
    assign restart    = cfg_wr || force_hunt || !mode_ok;
    assign hunt_shift = bit_vld && !restart && (state_q == ST_HUNT);
    assign asm_shift  = bit_vld && !restart && (state_q == ST_SYNC);
    assign close_pkt  = byte_done && byte_last;
    assign hunt_clr   = restart || (state_q != ST_HUNT) || (state_d != ST_HUNT);
    assign asm_clr    = restart || (state_q != ST_SYNC) || (state_d != ST_SYNC);

    bsr_cfg #(
        .REG_W    (REG_W),
        .BYTE_W   (BYTE_W),
        .MAX_SYNC (MAX_SYNC),
        .CNT_W    (CNT_W)
    ) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wdata   (cfg_wdata),
        .pat_we  (pat_we),
        .ctl_we  (ctl_we),
        .pattern (pattern),
        .len_sel (len_sel),
        .tc_en   (tc_en),
        .tc_val  (tc_val)
    );

    bsr_hunt #(
        .BYTE_W   (BYTE_W),
        .MAX_SYNC (MAX_SYNC)
    ) hunt_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (hunt_clr),
        .shift   (hunt_shift),
        .bit_in  (bit_in),
        .pattern (pattern),
        .len_sel (len_sel),
        .match   (hit)
    );

    bsr_assemble #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) asm_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (asm_clr),
        .shift     (asm_shift),
        .bit_in    (bit_in),
        .tc_en     (tc_en),
        .tc_val    (tc_val),
        .byte_done (byte_done),
        .byte_data (byte_data),
        .byte_last (byte_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!mode_ok) begin
            state_d = ST_IDLE;
        end else if (cfg_wr || force_hunt) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_HUNT;
                ST_HUNT: state_d = hit ? ST_SYNC : ST_HUNT;
                ST_SYNC: state_d = close_pkt ? ST_HUNT : ST_SYNC;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_vld <= 1'b0;
            byte_out <= '0;
            byte_eof <= 1'b0;
            sync_det <= 1'b0;
        end else begin
            byte_vld <= asm_shift && byte_done;
            byte_eof <= asm_shift && close_pkt;
            sync_det <= hit;
            if (asm_shift && byte_done) begin
                byte_out <= byte_data;
            end
        end
    end

    assign in_sync = (state_q == ST_SYNC);

    // R5: detection is a single-cycle pulse and coincides with sync
    a_r5_det_pulse: assert property (@(posedge clk) disable iff (rst)
        sync_det |=> !sync_det);
    a_r5_det_in_sync: assert property (@(posedge clk) disable iff (rst)
        sync_det |-> in_sync);

    // R6: a byte strobe is never followed by another on the next clock
    a_r6_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R7: end of frame rides on a byte and leaves sync
    a_r7_eof_with_byte: assert property (@(posedge clk) disable iff (rst)
        byte_eof |-> (byte_vld && !in_sync));

    // R8: no end of frame while terminal count is off
    a_r8_no_eof_disabled: assert property (@(posedge clk) disable iff (rst)
        !tc_en |-> !byte_eof);

    // R2: a foreign mode code leaves the receiver out of sync
    a_r2_mode_off: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |=> (!in_sync && !byte_vld && !sync_det));

    // R9: force-hunt drops sync and any completing byte
    a_r9_force: assert property (@(posedge clk) disable iff (rst)
        force_hunt |=> (!in_sync && !byte_vld));

    // R10: a register write drops sync
    a_r10_write_hunt: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (!in_sync && !byte_vld));

endmodule

// File: tb/bsr_top_tb_top.sv
module bsr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_wdata = '0;
    logic        pat_we = 1'b0;
    logic        ctl_we = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic        force_hunt = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        byte_vld;
    logic [7:0]  byte_out;
    logic        byte_eof;
    logic        in_sync;
    logic        sync_det;

    always #10 clk = ~clk;

    bsr_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_wdata  (cfg_wdata),
        .pat_we     (pat_we),
        .ctl_we     (ctl_we),
        .mode_sel   (mode_sel),
        .force_hunt (force_hunt),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .byte_vld   (byte_vld),
        .byte_out   (byte_out),
        .byte_eof   (byte_eof),
        .in_sync    (in_sync),
        .sync_det   (sync_det)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    gaps = 0;
    string req = "R1";
    bit    done_flag = 0;

    // reference model state
    int        m_st = 0;          // 0 idle, 1 hunt, 2 sync
    bit        m_hist[$];
    int        m_acc = 0;
    int        m_nbits = 0;
    int        m_cnt = 0;
    bit [31:0] m_pat = 0;
    int        m_len = 1;
    bit        m_tcen = 0;
    int        m_tc = 0;
    bit        e_vld = 0, e_eof = 0, e_det = 0;
    bit [7:0]  e_byte = 0;
    bit [7:0]  got[$];
    bit        got_eof[$];

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void m_enter_hunt();
        m_st = 1;
        m_hist.delete();
    endfunction

    function automatic void model_step();
        e_vld = 0; e_eof = 0; e_det = 0;
        if (rst) begin
            m_st = 0; m_hist.delete(); m_pat = 0; m_len = 1; m_tcen = 0; m_tc = 0;
            return;
        end
        if (pat_we) m_pat = cfg_wdata;
        if (ctl_we) begin
            m_len  = int'(cfg_wdata[18:17]) + 1;
            m_tcen = cfg_wdata[16];
            m_tc   = int'(cfg_wdata[15:0]);
        end
        if (mode_sel != 3'b101) begin
            m_st = 0;
        end else if (pat_we || ctl_we || force_hunt) begin
            m_enter_hunt();
        end else if (m_st == 0) begin
            m_enter_hunt();
        end else if (m_st == 1) begin
            if (bit_vld) begin
                int n;
                bit ok;
                m_hist.push_back(bit_in);
                if (m_hist.size() > 40) void'(m_hist.pop_front());
                n = m_len * 8;
                if (m_hist.size() >= n) begin
                    ok = 1;
                    for (int k = 0; k < n; k++)
                        if (m_hist[m_hist.size() - n + k] != m_pat[n - 1 - k]) ok = 0;
                    if (ok) begin
                        m_st = 2; e_det = 1; m_acc = 0; m_nbits = 0; m_cnt = 0;
                    end
                end
            end
        end else begin
            if (bit_vld) begin
                m_acc = ((m_acc << 1) | int'(bit_in)) & 8'hFF;
                m_nbits++;
                if (m_nbits == 8) begin
                    e_vld = 1; e_byte = 8'(m_acc); m_nbits = 0; m_acc = 0;
                    if (m_tcen && m_cnt == m_tc) begin
                        e_eof = 1; m_enter_hunt();
                    end
                    m_cnt++;
                end
            end
        end
    endfunction

    task automatic step();
        model_step();
        @(posedge clk);
        #2;
        cycles++;
        check(req, "in_sync", int'(in_sync), int'(m_st == 2));
        check(req, "sync_det", int'(sync_det), int'(e_det));
        check(req, "byte_vld", int'(byte_vld), int'(e_vld));
        check(req, "byte_eof", int'(byte_eof), int'(e_eof));
        if (e_vld) check(req, "byte_out", int'(byte_out), int'(e_byte));
        if (byte_vld) begin
            got.push_back(byte_out);
            got_eof.push_back(byte_eof);
        end
    endtask

    task automatic send_bit(input bit b);
        bit_vld = 1'b1; bit_in = b;
        step();
        bit_vld = 1'b0;
        if (gaps) begin
            int g = int'($urandom_range(0, 2));
            for (int i = 0; i < g; i++) step();
        end
    endtask

    task automatic send_byte(input bit [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic wr_pat(input bit [31:0] v);
        cfg_wdata = v; pat_we = 1'b1; step(); pat_we = 1'b0;
    endtask

    task automatic wr_ctl(input bit [31:0] v);
        cfg_wdata = v; ctl_we = 1'b1; step(); ctl_we = 1'b0;
    endtask

    task automatic expect_got(input string tag, input bit [7:0] exp_b[$], input bit exp_e[$]);
        check(tag, "byte count", got.size(), exp_b.size());
        if (got.size() == exp_b.size()) begin
            foreach (exp_b[i]) begin
                check(tag, "byte", int'(got[i]), int'(exp_b[i]));
                check(tag, "eof", int'(got_eof[i]), int'(exp_e[i]));
            end
        end
        got.delete(); got_eof.delete();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        while (cycles < 20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        finish_run();
    end

    initial begin
        // R1: reset state
        req = "R1";
        step(); step(); step();
        check("R1", "reset in_sync", int'(in_sync), 0);
        check("R1", "reset byte_vld", int'(byte_vld), 0);
        check("R1", "reset sync_det", int'(sync_det), 0);
        rst = 1'b0;
        mode_sel = 3'b101;
        step();

        // R3 / R6 / R8: one-byte pattern, no terminal count
        req = "R8";
        wr_pat(32'h0000_007E);
        wr_ctl(32'h0000_0000);
        send_byte(8'h00); send_byte(8'h7E);
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h7E); send_byte(8'h11);
        check("R8", "still in sync", int'(in_sync), 1);
        expect_got("R6", '{8'hA5, 8'h3C, 8'h7E, 8'h11}, '{0, 0, 0, 0});

        // R3 / R7 / R11: two-byte pattern, reserved bits set, 3-byte packets
        req = "R7";
        wr_pat(32'h0000_EB90);
        wr_ctl(32'hFFFB_0002);
        send_byte(8'h55); send_byte(8'hEB); send_byte(8'h90);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        check("R7", "hunt after eof", int'(in_sync), 0);
        send_byte(8'h04);
        send_byte(8'hEB); send_byte(8'h90);
        send_byte(8'h0A); send_byte(8'h0B); send_byte(8'h0C);
        expect_got("R11", '{8'h01, 8'h02, 8'h03, 8'h0A, 8'h0B, 8'h0C}, '{0, 0, 1, 0, 0, 1});

        // R3 / R7: four-byte pattern, one-byte packets
        req = "R3";
        wr_pat(32'h1ACF_FC1D);
        wr_ctl(32'h0007_0000);
        send_byte(8'hFF);
        send_byte(8'h1A); send_byte(8'hCF); send_byte(8'hFC); send_byte(8'h1D);
        send_byte(8'h42); send_byte(8'h43);
        expect_got("R3", '{8'h42}, '{1});

        // R4 / R10: pattern split around a register write must not match
        req = "R4";
        wr_pat(32'h00AB_CDEF);
        wr_ctl(32'h0004_0000);
        send_byte(8'hAB);
        wr_ctl(32'h0004_0000);
        send_byte(8'hCD); send_byte(8'hEF); send_byte(8'h77);
        check("R4", "no sync across write", int'(in_sync), 0);
        send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF); send_byte(8'h77);
        expect_got("R4", '{8'h77}, '{0});

        // R10: write during sync
        req = "R10";
        send_bit(1'b1); send_bit(1'b0);
        wr_pat(32'h00AB_CDEF);
        check("R10", "write drops sync", int'(in_sync), 0);
        send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF); send_byte(8'h5A);
        expect_got("R10", '{8'h5A}, '{0});

        // R9: force hunt in mid byte
        req = "R9";
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        force_hunt = 1'b1; step(); force_hunt = 1'b0;
        check("R9", "forced hunt", int'(in_sync), 0);
        send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF); send_byte(8'h3C);
        expect_got("R9", '{8'h3C}, '{0});

        // R2: foreign mode code
        req = "R2";
        send_byte(8'h99);
        mode_sel = 3'b100; step();
        check("R2", "mode off drops sync", int'(in_sync), 0);
        send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF); send_byte(8'h12);
        check("R2", "no sync in other mode", int'(in_sync), 0);
        mode_sel = 3'b101; step();
        send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF); send_byte(8'h21);
        expect_got("R2", '{8'h99, 8'h21}, '{0, 0});

        // R5 / R6: gapped strobes, four-byte packet
        req = "R5";
        gaps = 1;
        wr_pat(32'h0000_007E);
        wr_ctl(32'h0001_0003);
        send_byte(8'h7E);
        send_byte(8'h10); send_byte(8'h20); send_byte(8'h30); send_byte(8'h40);
        send_byte(8'h50);
        gaps = 0;
        expect_got("R5", '{8'h10, 8'h20, 8'h30, 8'h40}, '{0, 0, 0, 1});

        step(); step();
        finish_run();
    end

endmodule